// File: doc/BRIEF.md
# DDR Address Decoder and Open-Row Classifier

This block sits at the front of a DDR memory command path. Each accepted command carries a 32-bit byte address and a read/write direction. The block cuts the address into column, rank, row and bank fields using a fixed bit-field map. It keeps a small table of which row is currently open in each bank. From that table it tells the scheduler behind it what the command costs:
- a row hit;
- an activate into a closed bank;
- a precharge followed by an activate.

It also marks a change of direction against the previous command. At most three banks are held open at once. When a command needs a fourth bank, the least recently used open bank is named for precharge, and the new bank takes its slot.

Commands enter on a valid/ready handshake. Results leave through one output register stage that holds its contents while the consumer stalls. A management-enable input turns the open-row tracking off. While it is off, every access is treated as a full precharge and activate, and the table is emptied.

Top module: `ddr_addr_classifier`

## Requirements
- R1: Address bits 2:0 have no effect on any output; the column is address bits 12:3 and the rank is bit 13.
- R2: The row is address bits 27:14 and the bank is bits 29:28; bits 31:30 have no effect on any output.
- R3: When the row width in use is set to 13, address bit 27 is ignored: the row output's top bit reads 0, and two addresses that differ only in bit 27 hit the same open row.
- R4: The class output encodes 2'b00 for a hit, which is a command to a bank whose open row equals the command's row. The code 2'b11 is never produced.
- R5: A command to a closed bank is classed 2'b01 (activate only). A command to an open bank on a different row is classed 2'b10 (precharge then activate), and that row becomes the bank's open row.
- R6: No more than MAX_OPEN (3) banks are open at once. A command that opens a bank while three are open raises the evict flag and names the least recently used open bank, which becomes closed. The evict flag is 0 for every other command.
- R7: The turnaround flag is 1 when the command's direction differs from the previous accepted command's direction. It is 0 for the first command after reset.
- R8: With the management-enable input low, a command is classed 2'b10 with no eviction and all banks become closed. The next managed command is therefore classed 2'b01.
- R9: cmd_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, every output holds its value and no command is taken.
- R10: After reset, out_valid is 0, cmd_ready is 1 and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_addr | input | 32 | Byte address of the command |
| cmd_read | input | 1 | 1 for a read, 0 for a write |
| bank_mgmt_en | input | 1 | 1 enables open-row tracking |
| out_valid | output | 1 | Result register holds a classified command |
| out_ready | input | 1 | Consumer takes the result |
| out_col | output | 10 | Column field |
| out_rank | output | 1 | Rank select |
| out_row | output | 14 | Row field, unused top bits forced to 0 |
| out_bank | output | 2 | Bank field |
| out_class | output | 2 | 00 hit, 01 activate, 10 precharge+activate |
| out_turn | output | 1 | Direction changed against the previous command |
| out_evict_valid | output | 1 | An open bank must be precharged to make room |
| out_evict_bank | output | 2 | Bank to precharge when out_evict_valid is set |

## Verification
The bench builds the block with four banks, a cap of three open banks and a row width in use of 13. With that setting the bit-27 aliasing can be observed, and an eviction happens every time a fourth bank is touched. A long pseudo-random command stream draws rows from a set of three values per bank. Hits, row conflicts, closed-bank activates, LRU evictions and direction changes therefore all occur many times. Every result is compared with an arithmetic model kept in the bench as a most-recent-first list. Directed cases cover field extraction with the ignored bits toggled, the management-off flush, and a consumer stall.

// File: rtl/ddr_cls_pkg.sv
package ddr_cls_pkg;
  typedef enum logic [1:0] {
    CLS_HIT     = 2'b00,
    CLS_ACT     = 2'b01,
    CLS_PRE_ACT = 2'b10,
    CLS_RSVD    = 2'b11
  } acc_class_e;
endpackage

// File: rtl/ddr_addr_split.sv
module ddr_addr_split #(
  parameter int ADDR_W   = 32,
  parameter int COL_LO   = 3,
  parameter int COL_W    = 10,
  parameter int RANK_BIT = 13,
  parameter int ROW_LO   = 14,
  parameter int ROW_W    = 14,
  parameter int ROW_USED = 14,
  parameter int BANK_LO  = 28,
  parameter int BANK_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [COL_W-1:0]  col,
  output logic              rank,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank
);
  assign col  = addr[COL_LO +: COL_W];
  assign rank = addr[RANK_BIT];
  assign bank = addr[BANK_LO +: BANK_W];

  for (genvar i = 0; i < ROW_W; i++) begin : g_row
    if (i < ROW_USED) begin : g_used
      assign row[i] = addr[ROW_LO+i];
    end else begin : g_zero
      assign row[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_cls_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 14,
  parameter int MAX_OPEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              mgmt_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output acc_class_e        cls,
  output logic              evict_valid,
  output logic [BANK_W-1:0] evict_bank
);
  localparam int NBANK = 1 << BANK_W;
  localparam int AGE_W = $clog2(MAX_OPEN + 1);
  localparam int CNT_W = $clog2(NBANK + 1);

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] row_q [NBANK];
  logic [AGE_W-1:0] age_q [NBANK];

  logic [CNT_W-1:0]  open_cnt;
  logic [BANK_W-1:0] lru;
  logic [AGE_W-1:0]  best_age;
  logic              hit;

  always_comb begin
    open_cnt = '0;
    lru      = '0;
    best_age = '0;
    for (int i = 0; i < NBANK; i++) begin
      open_cnt = open_cnt + CNT_W'(open_q[i]);
      if (open_q[i] && age_q[i] >= best_age) begin
        best_age = age_q[i];
        lru      = BANK_W'(i);
      end
    end
  end

  assign hit = open_q[bank] && (row_q[bank] == row);

  always_comb begin
    evict_valid = 1'b0;
    evict_bank  = lru;
    if (!mgmt_en) begin
      cls = CLS_PRE_ACT;
    end else if (open_q[bank]) begin
      cls = hit ? CLS_HIT : CLS_PRE_ACT;
    end else begin
      cls         = CLS_ACT;
      evict_valid = (open_cnt >= CNT_W'(MAX_OPEN));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
      for (int i = 0; i < NBANK; i++) age_q[i] <= '0;
    end else if (upd) begin
      if (!mgmt_en) begin
        open_q <= '0;
        for (int i = 0; i < NBANK; i++) age_q[i] <= '0;
      end else begin
        for (int i = 0; i < NBANK; i++) begin
          if (BANK_W'(i) == bank) begin
            age_q[i] <= '0;
          end else if (open_q[i] && (!open_q[bank] || age_q[i] < age_q[bank])) begin
            age_q[i] <= age_q[i] + 1'b1;
          end
        end
        if (evict_valid) open_q[lru] <= 1'b0;
        open_q[bank] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd && mgmt_en) row_q[bank] <= row;
  end

  // R6
  max_open_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(open_q) <= MAX_OPEN);

  // R6
  evict_open_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && evict_valid) |-> (open_q[evict_bank] && !open_q[bank]));

  // R6
  evict_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && evict_valid) |=> !open_q[$past(evict_bank)]);
endmodule

// File: rtl/ddr_addr_classifier.sv
module ddr_addr_classifier
  import ddr_cls_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int COL_LO   = 3,
  parameter int COL_W    = 10,
  parameter int RANK_BIT = 13,
  parameter int ROW_LO   = 14,
  parameter int ROW_W    = 14,
  parameter int ROW_USED = 14,
  parameter int BANK_LO  = 28,
  parameter int BANK_W   = 2,
  parameter int MAX_OPEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_read,
  input  logic              bank_mgmt_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COL_W-1:0]  out_col,
  output logic              out_rank,
  output logic [ROW_W-1:0]  out_row,
  output logic [BANK_W-1:0] out_bank,
  output logic [1:0]        out_class,
  output logic              out_turn,
  output logic              out_evict_valid,
  output logic [BANK_W-1:0] out_evict_bank
);
  logic [COL_W-1:0]  s_col;
  logic              s_rank;
  logic [ROW_W-1:0]  s_row;
  logic [BANK_W-1:0] s_bank;
  acc_class_e        t_cls;
  logic              t_ev;
  logic [BANK_W-1:0] t_evb;
  logic              take;
  logic              last_read_q, have_last_q;

  assign cmd_ready = !out_valid || out_ready;
  assign take      = cmd_valid && cmd_ready;

  ddr_addr_split #(
    .ADDR_W(ADDR_W), .COL_LO(COL_LO), .COL_W(COL_W), .RANK_BIT(RANK_BIT),
    .ROW_LO(ROW_LO), .ROW_W(ROW_W), .ROW_USED(ROW_USED),
    .BANK_LO(BANK_LO), .BANK_W(BANK_W)
  ) u_split (
    .addr(cmd_addr), .col(s_col), .rank(s_rank), .row(s_row), .bank(s_bank)
  );

  ddr_bank_tracker #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .MAX_OPEN(MAX_OPEN)
  ) u_track (
    .clk(clk), .rst(rst), .upd(take), .mgmt_en(bank_mgmt_en),
    .bank(s_bank), .row(s_row),
    .cls(t_cls), .evict_valid(t_ev), .evict_bank(t_evb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      have_last_q     <= 1'b0;
      last_read_q     <= 1'b0;
      out_col         <= '0;
      out_rank        <= 1'b0;
      out_row         <= '0;
      out_bank        <= '0;
      out_class       <= 2'b00;
      out_turn        <= 1'b0;
      out_evict_valid <= 1'b0;
      out_evict_bank  <= '0;
    end else if (take) begin
      out_valid       <= 1'b1;
      have_last_q     <= 1'b1;
      last_read_q     <= cmd_read;
      out_col         <= s_col;
      out_rank        <= s_rank;
      out_row         <= s_row;
      out_bank        <= s_bank;
      out_class       <= t_cls;
      out_turn        <= have_last_q && (cmd_read != last_read_q);
      out_evict_valid <= t_ev;
      out_evict_bank  <= t_evb;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R4
  no_rsvd_class_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_class != CLS_RSVD);

  // R6
  evict_only_act_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_evict_valid) |-> out_class == CLS_ACT);

  // R8
  mgmt_off_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !bank_mgmt_en) |=> (out_class == CLS_PRE_ACT && !out_evict_valid));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_class) &&
      $stable(out_row) && $stable(out_col) && $stable(out_bank) && $stable(out_turn)));
endmodule

// File: tb/ddr_addr_classifier_bench.sv
module ddr_addr_classifier_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_ready, cmd_read, bank_mgmt_en;
  logic [31:0] cmd_addr;
  logic        out_valid, out_ready;
  logic [9:0]  out_col;
  logic        out_rank;
  logic [13:0] out_row;
  logic [1:0]  out_bank, out_class, out_evict_bank;
  logic        out_turn, out_evict_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ddr_addr_classifier #(.ROW_USED(13)) u_ddr_addr_classifier (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_read(cmd_read), .bank_mgmt_en(bank_mgmt_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col),
    .out_rank(out_rank), .out_row(out_row), .out_bank(out_bank),
    .out_class(out_class), .out_turn(out_turn),
    .out_evict_valid(out_evict_valid), .out_evict_bank(out_evict_bank)
  );

  // reference model state
  bit        m_open [4];
  int        m_row  [4];
  int        m_ord  [4];
  int        m_n;
  bit        m_have, m_last;
  int        e_cls, e_ev, e_evb, e_turn;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(int top, int bank, int row, int rank, int col, int low);
    return {top[1:0], bank[1:0], row[13:0], rank[0], col[9:0], low[2:0]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; m_ord[i] = 0; end
    m_n = 0; m_have = 0; m_last = 0;
  endtask

  task automatic model_step(logic [31:0] a, bit rd, bit mg);
    int b, r, pos;
    b = int'(a[29:28]);
    r = int'(a[26:14]);
    e_turn = (m_have && (rd != m_last)) ? 1 : 0;
    m_have = 1; m_last = rd;
    e_ev = 0; e_evb = -1;
    if (!mg) begin
      e_cls = 2;
      for (int i = 0; i < 4; i++) m_open[i] = 0;
      m_n = 0;
      return;
    end
    if (m_open[b]) begin
      e_cls = (m_row[b] == r) ? 0 : 2;
      pos = 0;
      for (int i = 0; i < m_n; i++) if (m_ord[i] == b) pos = i;
      for (int i = pos; i > 0; i--) m_ord[i] = m_ord[i-1];
      m_ord[0] = b;
    end else begin
      e_cls = 1;
      if (m_n == 3) begin
        e_ev = 1; e_evb = m_ord[2];
        m_open[m_ord[2]] = 0;
        m_n = 2;
      end
      for (int i = m_n; i > 0; i--) m_ord[i] = m_ord[i-1];
      m_ord[0] = b;
      m_n++;
      m_open[b] = 1;
    end
    m_row[b] = r;
  endtask

  task automatic issue(logic [31:0] a, bit rd, bit mg);
    @(negedge clk);
    cmd_addr = a; cmd_read = rd; bank_mgmt_en = mg; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_step(a, rd, mg);
  endtask

  task automatic check_result(string tag);
    chk({tag, " R9 valid"}, int'(out_valid), 1);
    chk({tag, " R4 R5 class"}, int'(out_class), e_cls);
    chk({tag, " R7 turn"}, int'(out_turn), e_turn);
    chk({tag, " R6 evict"}, int'(out_evict_valid), e_ev);
    if (e_ev == 1) chk({tag, " R6 evict bank"}, int'(out_evict_bank), e_evb);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int unsigned seed;
    rst = 1'b1; cmd_valid = 1'b0; cmd_addr = '0; cmd_read = 1'b0;
    bank_mgmt_en = 1'b1; out_ready = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 cmd_ready", int'(cmd_ready), 1);

    // R1 R2 field split, ignored low and high bits toggled
    for (int k = 0; k < 16; k++) begin
      int bk, rw, rk, cl;
      bk = k % 4; rw = (k * 937) & 16'h1fff; rk = k % 2; cl = (k * 71) & 10'h3ff;
      a = mk(k % 4, bk, rw, rk, cl, k % 8);
      issue(a, k[0], 1'b1);
      chk("R1 column", int'(out_col), cl);
      chk("R1 rank", int'(out_rank), rk);
      chk("R2 row", int'(out_row), rw);
      chk("R2 bank", int'(out_bank), bk);
      check_result("R1R2");
    end

    // R8 flush, then R3 aliasing of bit 27
    issue(mk(0, 2, 5, 0, 0, 0), 1'b0, 1'b0);
    check_result("R8 off");
    issue(mk(0, 1, 5, 0, 0, 0), 1'b0, 1'b1);
    chk("R8 after flush act", int'(out_class), 1);
    check_result("R8 next");
    issue(mk(0, 1, 5 | 14'h2000, 0, 8, 0), 1'b0, 1'b1);
    chk("R3 row msb zero", int'(out_row[13]), 0);
    chk("R3 alias hit", int'(out_class), 0);
    check_result("R3");

    // R9 stall
    issue(mk(0, 3, 7, 1, 3, 0), 1'b1, 1'b1);
    check_result("R9 first");
    out_ready = 1'b0;
    cmd_addr = mk(0, 0, 9, 0, 4, 0); cmd_read = 1'b0; bank_mgmt_en = 1'b1; cmd_valid = 1'b1;
    #1;
    chk("R9 cmd_ready low", int'(cmd_ready), 0);
    @(negedge clk);
    chk("R9 held row", int'(out_row), 7);
    chk("R9 held bank", int'(out_bank), 3);
    chk("R9 held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    #1;
    chk("R9 cmd_ready high", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    model_step(mk(0, 0, 9, 0, 4, 0), 1'b0, 1'b1);
    chk("R9 new bank", int'(out_bank), 0);
    check_result("R9 second");

    // R4 R5 R6 R7 pseudo-random sweep
    seed = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      int bk, rw;
      bit rd, mg;
      seed = seed * 32'd1664525 + 32'd1013904223;
      bk = int'(seed[31:30]);
      rw = int'(seed[29:28]) % 3;
      if (seed[20]) rw = rw | 14'h2000;
      rd = seed[24] & seed[25];
      mg = (seed[15:10] != 6'd0);
      a = mk(int'(seed[9:8]), bk, rw, int'(seed[7]), int'(seed[17:8]), int'(seed[3:1]));
      issue(a, rd, mg);
      check_result("sweep");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule